// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with LED Blink

This block manages eight general purpose pins through a small register port. Each pin is either an input or an output, set by its own direction bit. An output pin drives a fixed level from a register. It can also be switched to blink mode, where it follows a shared square wave meant for driving an LED.

One shared counter sets the blink timing. It counts a programmable half period, and its reset value gives a 100 ms full blink period at a 25 MHz clock (1,250,000 cycles high, then 1,250,000 cycles low). Each input pin passes through a two-flop synchroniser. It can then raise an interrupt, either on an edge of a chosen polarity (with a sticky status bit) or while it sits at a chosen active level. A per-pin enable gates every status bit into one registered interrupt line.

Registers are written on a clock edge when the write strobe is high. Reads are combinational from the address.

Top module: `gpioBlink`

## Requirements
- R1: After reset every configuration register and every status bit is 0, `pinOe` and `irq` are 0, and the half-period register (address 7) reads 1250000.
- R2: Address 0 holds the direction bits (1 = output). `pinOe` equals this register from the cycle after the write.
- R3: A pin that is an output and not blinking drives the bit of the output-value register (address 1) on `pinOut`.
- R4: An output pin whose bit is set in the blink register (address 2) drives a shared phase. All blinking pins show the same value. The phase toggles each time the counter has run through the half-period count (address 7, a value of 0 behaves as 1).
- R5: Writing address 7 restarts the counter and holds the phase in that cycle. The first toggle after a write of N comes exactly N clock edges after the write edge.
- R6: Inputs are synchronised by two flops. In edge mode (bit 0 at address 4), a transition to the polarity set at address 5 (1 = rising, 0 = falling) sets a sticky status bit, read at address 6.
- R7: Writing 1 to a status bit at address 6 clears a sticky bit. If an edge arrives in the same cycle as the clear, the bit stays set.
- R8: In level mode (bit 1 at address 4), the status bit is 1 exactly while the synchronised input equals the polarity bit. It clears without any write.
- R9: `irq` is a registered OR of the status bits ANDed with the enable register (address 3). A masked pin never raises `irq`, and `irq` falls one cycle after the last enabled status goes away.
- R10: A pin set as an output never shows status and never contributes to `irq`.
- R11: The blink bit has no effect on an input pin: `pinOe` stays 0 and `pinOut` keeps the output-value bit.
- R12: Reads of addresses 0 to 7 return the registers and status as listed above, zero-extended. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (25 MHz in the target system) |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 24 | Write data |
| regRdData | output | 24 | Read data for `regAddr` |
| pinIn | input | 8 | Pin levels from the pads |
| pinOe | output | 8 | Per-pin output enable |
| pinOut | output | 8 | Per-pin output level |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach from the ports are the coincidences. A sticky clear can land in the same cycle as a fresh edge. A period write can land on the cycle where the counter would wrap. A pin's direction or mode can change while an old transition is still moving through the synchroniser. A directed phase sets up each mode on its own and measures the restart-to-toggle distance. A long random phase then drives new pin levels every cycle and issues writes to random addresses, with short half periods. A cycle-accurate behavioural model compares every output and the read data on every clock, so these collisions happen many times.

// File: rtl/gpioBlinkPkg.sv
package gpioBlinkPkg;
  localparam int PIN_CNT  = 8;
  localparam int TIMER_W  = 24;
  localparam int DATA_W   = 24;
  localparam int ADDR_W   = 4;
  localparam int HALF_RST = 1250000;

  localparam logic [ADDR_W-1:0] A_DIR   = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUTV  = 4'd1;
  localparam logic [ADDR_W-1:0] A_BLINK = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd4;
  localparam logic [ADDR_W-1:0] A_POL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_HALF  = 4'd7;

  typedef struct packed {
    logic [PIN_CNT-1:0] clrMask;
    logic               periodWr;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpioBlinkTimer.sv
module gpioBlinkTimer
  import gpioBlinkPkg::*;
#(
  parameter int TW = TIMER_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic [TW-1:0] halfCount,
  output logic          phase
);
  logic [TW-1:0] cnt;
  logic [TW:0]   cntNext;
  logic          wrap;

  assign cntNext = {1'b0, cnt} + 1'b1;
  assign wrap    = cntNext >= {1'b0, halfCount};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cntNext[TW-1:0];
    end
  end

  assert_restart_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> $stable(phase));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cnt < halfCount) || (cnt == '0));
endmodule

// File: rtl/gpioPinPath.sv
module gpioPinPath
  import gpioBlinkPkg::*;
#(
  parameter int P  = PIN_CNT,
  parameter int TW = TIMER_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [P-1:0]  pinIn,
  input  logic [P-1:0]  dirOut,
  input  logic [P-1:0]  outValue,
  input  logic [P-1:0]  blinkSel,
  input  logic [P-1:0]  lvlMode,
  input  logic [P-1:0]  activePol,
  input  ctrlStrobe_t   strb,
  input  logic [TW-1:0] halfPeriod,
  output logic [P-1:0]  pendingVec,
  output logic [P-1:0]  pinOe,
  output logic [P-1:0]  pinOut
);
  logic [P-1:0] syncA, syncB, syncPrev, sticky;
  logic [P-1:0] edgeHit, levelHit;
  logic         blinkPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
      sticky   <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      sticky   <= (sticky & ~strb.clrMask) | edgeHit;
    end
  end

  assign levelHit = ~(syncB ^ activePol);
  assign edgeHit  = ~dirOut & ~lvlMode & (syncB ^ syncPrev) & levelHit;
  assign pinOe    = dirOut;

  gpioBlinkTimer #(.TW(TW)) uTimer (
    .clk       (clk),
    .rstN      (rstN),
    .restart   (strb.periodWr),
    .halfCount (halfPeriod),
    .phase     (blinkPhase)
  );

  for (genvar i = 0; i < P; i++) begin : gPin
    assign pendingVec[i] = !dirOut[i] && (lvlMode[i] ? levelHit[i] : sticky[i]);
    assign pinOut[i]     = (dirOut[i] && blinkSel[i]) ? blinkPhase : outValue[i];
  end

  assert_sticky_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(sticky) & ~sticky & ~$past(strb.clrMask)) == '0));

  assert_no_out_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    (((sticky & ~$past(sticky)) & $past(dirOut)) == '0));
endmodule

// File: rtl/gpioRegCtrl.sv
module gpioRegCtrl
  import gpioBlinkPkg::*;
#(
  parameter int P        = PIN_CNT,
  parameter int TW       = TIMER_W,
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int HALF_DEF = HALF_RST
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic [P-1:0]  pendingVec,
  output logic [P-1:0]  dirOut,
  output logic [P-1:0]  outValue,
  output logic [P-1:0]  blinkSel,
  output logic [P-1:0]  lvlMode,
  output logic [P-1:0]  activePol,
  output logic [TW-1:0] halfPeriod,
  output ctrlStrobe_t   strb,
  output logic          irq
);
  localparam int PAD = DW - P;
  logic [P-1:0] intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirOut     <= '0;
      outValue   <= '0;
      blinkSel   <= '0;
      intEn      <= '0;
      lvlMode    <= '0;
      activePol  <= '0;
      halfPeriod <= TW'(HALF_DEF);
      irq        <= 1'b0;
    end else begin
      irq <= |(pendingVec & intEn);
      if (regWrEn) begin
        case (regAddr)
          A_DIR:   dirOut     <= regWrData[P-1:0];
          A_OUTV:  outValue   <= regWrData[P-1:0];
          A_BLINK: blinkSel   <= regWrData[P-1:0];
          A_IEN:   intEn      <= regWrData[P-1:0];
          A_MODE:  lvlMode    <= regWrData[P-1:0];
          A_POL:   activePol  <= regWrData[P-1:0];
          A_HALF:  halfPeriod <= regWrData[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.clrMask  = (regWrEn && regAddr == A_STAT) ? regWrData[P-1:0] : '0;
    strb.periodWr = regWrEn && regAddr == A_HALF;
  end

  always_comb begin
    case (regAddr)
      A_DIR:   regRdData = {{PAD{1'b0}}, dirOut};
      A_OUTV:  regRdData = {{PAD{1'b0}}, outValue};
      A_BLINK: regRdData = {{PAD{1'b0}}, blinkSel};
      A_IEN:   regRdData = {{PAD{1'b0}}, intEn};
      A_MODE:  regRdData = {{PAD{1'b0}}, lvlMode};
      A_POL:   regRdData = {{PAD{1'b0}}, activePol};
      A_STAT:  regRdData = {{PAD{1'b0}}, pendingVec};
      A_HALF:  regRdData = DW'(halfPeriod);
      default: regRdData = '0;
    endcase
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|intEn));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0 && $past(intEn) == '0) |-> !irq);
endmodule

// File: rtl/gpioBlink.sv
module gpioBlink
  import gpioBlinkPkg::*;
#(
  parameter int HALF_DEF = HALF_RST
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [PIN_CNT-1:0] pinOe,
  output logic [PIN_CNT-1:0] pinOut,
  output logic              irq
);
  logic [PIN_CNT-1:0] pendingVec, dirOut, outValue, blinkSel, lvlMode, activePol;
  logic [TIMER_W-1:0] halfPeriod;
  ctrlStrobe_t        strb;

  gpioRegCtrl #(.HALF_DEF(HALF_DEF)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .pendingVec (pendingVec),
    .dirOut     (dirOut),
    .outValue   (outValue),
    .blinkSel   (blinkSel),
    .lvlMode    (lvlMode),
    .activePol  (activePol),
    .halfPeriod (halfPeriod),
    .strb       (strb),
    .irq        (irq)
  );

  gpioPinPath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .dirOut     (dirOut),
    .outValue   (outValue),
    .blinkSel   (blinkSel),
    .lvlMode    (lvlMode),
    .activePol  (activePol),
    .strb       (strb),
    .halfPeriod (halfPeriod),
    .pendingVec (pendingVec),
    .pinOe      (pinOe),
    .pinOut     (pinOut)
  );
endmodule

// File: tb/gpioBlink_test.sv
module gpioBlink_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = 4'd7;
  logic [23:0] regWrData = '0;
  logic [7:0]  pinIn = '0;
  logic [23:0] regRdData;
  logic [7:0]  pinOe, pinOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpioBlink uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOe(pinOe), .pinOut(pinOut), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit [7:0] mDir, mOut, mBlink, mEn, mLvl, mPol, s1, s2, sp, mSticky;
  int       mHalf, mCnt;
  bit       mPhase, mIrq;

  function automatic bit [7:0] mPend();
    bit [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (!mDir[i]) r[i] = mLvl[i] ? (s2[i] == mPol[i]) : mSticky[i];
    return r;
  endfunction

  function automatic bit [7:0] mPinOut();
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (mDir[i] && mBlink[i]) ? mPhase : mOut[i];
    return r;
  endfunction

  function automatic int mRead(int a);
    case (a)
      0: return int'(mDir);
      1: return int'(mOut);
      2: return int'(mBlink);
      3: return int'(mEn);
      4: return int'(mLvl);
      5: return int'(mPol);
      6: return int'(mPend());
      7: return mHalf;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [7:0] hit, clr;
    bit irqN;
    if (!rstN) begin
      mDir = 0; mOut = 0; mBlink = 0; mEn = 0; mLvl = 0; mPol = 0;
      s1 = 0; s2 = 0; sp = 0; mSticky = 0; mHalf = 1250000; mCnt = 0;
      mPhase = 0; mIrq = 0;
    end else begin
      hit = 0;
      for (int i = 0; i < 8; i++)
        if (!mDir[i] && !mLvl[i] && s2[i] != sp[i] && s2[i] == mPol[i]) hit[i] = 1;
      irqN = |(mPend() & mEn);
      clr = (regWrEn && regAddr == 6) ? regWrData[7:0] : 8'h0;
      if (regWrEn && regAddr == 7) mCnt = 0;
      else if (mCnt + 1 >= mHalf) begin mCnt = 0; mPhase = ~mPhase; end
      else mCnt++;
      if (regWrEn) case (regAddr)
        0: mDir = regWrData[7:0];
        1: mOut = regWrData[7:0];
        2: mBlink = regWrData[7:0];
        3: mEn = regWrData[7:0];
        4: mLvl = regWrData[7:0];
        5: mPol = regWrData[7:0];
        7: mHalf = int'(regWrData);
        default: ;
      endcase
      mSticky = (mSticky & ~clr) | hit;
      mIrq = irqN;
      sp = s2; s2 = s1; s1 = pinIn;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rstN && !done) begin
    check(pinOe == mDir, "R2 pinOe", 32'(pinOe), 32'(mDir));
    check(pinOut == mPinOut(), (|(mDir & mBlink)) ? "R4 pinOut" : "R3 pinOut",
          32'(pinOut), 32'(mPinOut()));
    check(irq == mIrq, "R9 irq", 32'(irq), 32'(mIrq));
    check(int'(regRdData) == mRead(int'(regAddr)), "R12 read",
          32'(regRdData), 32'(mRead(int'(regAddr))));
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    regWrEn = 1; regAddr = 4'(a); regWrData = 24'(d);
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic rdChk(int a, int exp, string tag);
    @(posedge clk); #1;
    regAddr = 4'(a);
    @(negedge clk);
    check(int'(regRdData) == exp, tag, 32'(regRdData), 32'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int got;
    bit ph0;
    repeat (3) @(negedge clk);
    check(pinOe == 8'h00, "R1 oe", 32'(pinOe), 0);
    check(irq == 1'b0, "R1 irq", 32'(irq), 0);
    check(regRdData == 24'd1250000, "R1 half", 32'(regRdData), 1250000);
    @(posedge clk); #1; rstN = 1;
    rdChk(0, 0, "R1 dir");

    wr(0, 8'hF0); wr(1, 8'hA5);
    @(negedge clk);
    check(pinOe == 8'hF0, "R2 oe", 32'(pinOe), 32'hF0);
    check(pinOut == 8'hA5, "R3 level", 32'(pinOut), 32'hA5);

    wr(7, 4); wr(2, 8'h3C);
    idle(3); @(negedge clk);
    check(pinOut[4] == pinOut[5], "R4 shared", 32'(pinOut[5:4]), 32'(pinOut[4] ? 3 : 0));
    check(pinOut[3:2] == 2'b01, "R11 blink ignored", 32'(pinOut[3:2]), 1);
    wr(7, 6);
    ph0 = pinOut[4]; got = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); #1;
      if (pinOut[4] != ph0 && got == 0) got = k;
    end
    check(got == 6, "R5 restart", 32'(got), 6);

    wr(5, 8'h01); wr(3, 8'h0F);
    pinIn = 8'h01; idle(5);
    rdChk(6, 8'h01, "R6 rise");
    @(negedge clk); check(irq == 1'b1, "R9 set", 32'(irq), 1);
    pinIn = 8'h03; idle(4); pinIn = 8'h01; idle(5);
    rdChk(6, 8'h03, "R6 fall");
    wr(6, 8'h03);
    rdChk(6, 0, "R7 clear");
    idle(1); @(negedge clk); check(irq == 1'b0, "R9 drop", 32'(irq), 0);
    wr(3, 8'h00); pinIn = 8'h00; idle(4); pinIn = 8'h01; idle(5);
    rdChk(6, 8'h01, "R9 masked status");
    @(negedge clk); check(irq == 1'b0, "R9 masked", 32'(irq), 0);
    wr(6, 8'hFF);

    wr(4, 8'h04); wr(3, 8'h04); pinIn = 8'h01; idle(5);
    rdChk(6, 8'h04, "R8 level");
    pinIn = 8'h05; idle(5);
    rdChk(6, 8'h00, "R8 follow");
    @(negedge clk); check(irq == 1'b0, "R8 irq", 32'(irq), 0);

    wr(4, 8'h00); wr(3, 8'hFF); wr(5, 8'hFF);
    pinIn = 8'hF4; idle(4); pinIn = 8'h04; idle(4); pinIn = 8'hF4; idle(5);
    rdChk(6, 8'h00, "R10 outputs");
    @(negedge clk); check(irq == 1'b0, "R10 irq", 32'(irq), 0);

    wr(9, 8'h55); rdChk(9, 0, "R12 unmapped");
    rdChk(0, 8'hF0, "R12 dir kept");

    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      pinIn = 8'($urandom);
      if ($urandom % 4 == 0) begin
        regWrEn = 1; regAddr = 4'($urandom % 10);
        regWrData = (regAddr == 7) ? 24'($urandom % 9) : 24'($urandom);
      end else begin
        regWrEn = 0; regAddr = 4'($urandom % 10);
      end
    end
    @(posedge clk); #1; regWrEn = 0;
    idle(2);
    done = 1;
    report();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R1-watchdog actual=hung expected=finish");
      report();
      $finish;
    end
  end
endmodule